// File: doc/BRIEF.md
# Monitor Register Readout Sequencer

This block produces the bytes that a serial read returns from a channel-monitoring converter. A bus front end raises a one-cycle byte request each time it needs another byte. The sequencer returns that byte one cycle later, and a stop-or-NACK input ends the read. The block does not handle bus bit timing.

In monitor mode the read returns three sections in order: the alarm-status word, one latched-fault word per conversion slot, and one current-result word per conversion slot. After the last result word, the stream loops back to the first result word. The result registers inside the block take no updates while a monitor read is in progress. In readback mode the stream returns the stored setup: one header byte, then a three-byte threshold set for each active channel. Every 16-bit word is sent high byte first.

Top module: `mon_readout`

## Requirements
- R1: After reset, byte_vld is 0, byte_out is 0, and all four current-result words are 0.
- R2: A byte_req with rd_end low is answered in the next cycle by exactly one byte_vld pulse. Words go out high byte first.
- R3: A monitor-mode read (cfg_sel not 2'b11) returns the alarm_word first, then fault slots 0..n-1 from fault_words (slot s at bits 16s+15:16s), then current-result slots 0..n-1.
- R4: The slot count n is cfg_last+1 when single-ended. When differential (cfg_diff=1), n counts the pairs whose lower channel is at or below cfg_last: 1 pair for cfg_last 0..1, 2 pairs for cfg_last 2..3.
- R5: After the last current-result byte, a monitor read continues with current-result slot 0. It does not return to the alarm word.
- R6: A result write (res_we, res_slot, res_data) is discarded while a monitor read is in progress. Writes take effect when no read is open, and also during a readback-mode read.
- R7: rd_end closes the read; the next byte_req starts again from the first byte of the sequence. When rd_end and byte_req are high together, rd_end wins and no byte is sent.
- R8: Readback mode is selected by cfg_sel == 2'b11. Its first byte is {4'b1111, cfg_speed[2:0], cfg_irq_en}. The four ones stand in the alarm-reset positions.
- R9: After the header, readback sends three bytes for each active channel: {thr_up[ch], thr_lo[ch]}, 24 bits, high byte first. Channels are in ascending order, and only even channels are sent when differential. After the last set, readback wraps to the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 2 | Channel-select field; 2'b11 selects readback |
| cfg_last | input | 2 | Highest channel in the scan |
| cfg_diff | input | 1 | 1 = channels paired 0/1 and 2/3 |
| cfg_speed | input | 3 | Scan-speed code for the readback header |
| cfg_irq_en | input | 1 | Interrupt-enable bit for the readback header |
| thr_up | input | 48 | Upper thresholds, 12 bits per channel, channel c at bits 12c+11:12c |
| thr_lo | input | 48 | Lower thresholds, same layout |
| alarm_word | input | 16 | Alarm-status word |
| fault_words | input | 64 | Latched-fault words, 16 bits per slot |
| res_we | input | 1 | Current-result write strobe |
| res_slot | input | 2 | Slot being written |
| res_data | input | 16 | Result word being written |
| byte_req | input | 1 | Request for the next byte |
| rd_end | input | 1 | Stop or NACK: closes the read |
| byte_out | output | 8 | Returned byte |
| byte_vld | output | 1 | byte_out valid for one cycle |

## Verification
The assertions assume that cfg_sel, cfg_last and cfg_diff stay fixed from the first byte_req of a read until its rd_end. They also assume that res_slot names an active slot whenever res_we is high. The bench changes configuration only between an rd_end and the next request, and writes only to slots within the current scan. Reads are run in both modes, in single-ended and differential forms, with requests spaced apart and back to back. Each read is made long enough to show the wrap.

// File: rtl/mon_readout.sv
module mon_readout #(
  parameter int NCH = 4,
  parameter int TW  = 12,
  parameter int WW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_sel,
  input  logic [1:0]        cfg_last,
  input  logic              cfg_diff,
  input  logic [2:0]        cfg_speed,
  input  logic              cfg_irq_en,
  input  logic [NCH*TW-1:0] thr_up,
  input  logic [NCH*TW-1:0] thr_lo,
  input  logic [WW-1:0]     alarm_word,
  input  logic [NCH*WW-1:0] fault_words,
  input  logic              res_we,
  input  logic [1:0]        res_slot,
  input  logic [WW-1:0]     res_data,
  input  logic              byte_req,
  input  logic              rd_end,
  output logic [7:0]        byte_out,
  output logic              byte_vld
);
  localparam int IW = 5;

  logic [WW-1:0] cur [NCH];
  logic          active;
  logic [IW-1:0] idx;

  wire          rb      = (cfg_sel == 2'b11);
  wire          frz     = active && !rb;
  wire [2:0]    nconv   = cfg_diff ? {2'b0, cfg_last[1]} + 3'd1 : {1'b0, cfg_last} + 3'd1;
  wire [IW-1:0] n5      = {2'b0, nconv};
  wire [IW-1:0] flt_end = 5'd2 + (n5 << 1);
  wire [IW-1:0] cur_end = 5'd2 + (n5 << 2);
  wire [IW-1:0] rb_end  = 5'd1 + n5 * 5'd3;
  wire [IW-1:0] last_ix = rb ? rb_end - 5'd1 : cur_end - 5'd1;
  wire [IW-1:0] wrap_ix = rb ? 5'd0 : flt_end;
  wire [IW-1:0] nxt_ix  = (idx == last_ix) ? wrap_ix : idx + 5'd1;
  wire          take    = byte_req && !rd_end;

  logic [7:0]    sel;
  logic [WW-1:0] word;
  logic [IW-1:0] j, q3, r3, d;
  logic [1:0]    ch;
  logic [2*TW-1:0] tset;

  always_comb begin
    sel  = '0;
    word = '0;
    j    = idx - 5'd1;
    q3   = j / 5'd3;
    r3   = j - q3 * 5'd3;
    d    = '0;
    ch   = cfg_diff ? {q3[0], 1'b0} : q3[1:0];
    tset = {thr_up[ch*TW +: TW], thr_lo[ch*TW +: TW]};
    if (rb) begin
      if (idx == 5'd0)      sel = {4'hF, cfg_speed, cfg_irq_en};
      else if (r3 == 5'd0)  sel = tset[23:16];
      else if (r3 == 5'd1)  sel = tset[15:8];
      else                  sel = tset[7:0];
    end else begin
      if (idx < 5'd2) begin
        word = alarm_word;
      end else if (idx < flt_end) begin
        d    = idx - 5'd2;
        word = fault_words[d[2:1]*WW +: WW];
      end else begin
        d    = idx - flt_end;
        word = cur[d[2:1]];
      end
      sel = idx[0] ? word[7:0] : word[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      active   <= 1'b0;
      byte_out <= '0;
      byte_vld <= 1'b0;
    end else if (rd_end) begin
      idx      <= '0;
      active   <= 1'b0;
      byte_vld <= 1'b0;
    end else if (byte_req) begin
      idx      <= nxt_ix;
      active   <= 1'b1;
      byte_out <= sel;
      byte_vld <= 1'b1;
    end else begin
      byte_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) cur[i] <= '0;
    end else if (res_we && !frz) begin
      cur[res_slot] <= res_data;
    end
  end

  wire [NCH*WW-1:0] cur_all = {cur[3], cur[2], cur[1], cur[0]};

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> byte_vld); // R2
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !byte_vld); // R7
  AST_FROZEN_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    frz |=> $stable(cur_all)); // R6
  AST_END_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> (idx == 5'd0) && !active); // R7
  AST_FIRST_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    take && !active && !rb |=> byte_out == $past(alarm_word[15:8])); // R3
  AST_RB_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    take && !active && rb |=> byte_out[7:4] == 4'hF); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last_ix); // R5
endmodule

// File: tb/sim_mon_readout.sv
module sim_mon_readout;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_sel = 0, cfg_last = 3, res_slot = 0;
  logic cfg_diff = 0, cfg_irq_en = 1, res_we = 0, byte_req = 0, rd_end = 0;
  logic [2:0] cfg_speed = 3'b101;
  logic [47:0] thr_up = 48'h7A1_6B2_5C3_4D4;
  logic [47:0] thr_lo = 48'h0E1_1F2_203_314;
  logic [15:0] alarm_word = 16'hA5C3, res_data = 0;
  logic [63:0] fault_words = 64'h4444_3333_2222_1111;
  logic [7:0] byte_out;
  logic byte_vld;

  mon_readout u0 (.*);

  always #(PER/2) clk = ~clk;

  int checks = 0, errors = 0, k = 0;
  bit rd_on = 0;
  logic [15:0] mcur [4] = '{default: 16'h0};
  logic [7:0] expq [$];
  int tagq [$];

  task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", rq, act, exp); end
  endtask

  function automatic logic [7:0] exp_at(int n);
    logic [7:0] s [$];
    int ws;
    int cnt = cfg_diff ? (cfg_last >= 2 ? 2 : 1) : int'(cfg_last) + 1;
    if (cfg_sel == 2'b11) begin
      s.push_back({4'hF, cfg_speed, cfg_irq_en});
      for (int c = 0; c < 4; c++)
        if (c <= int'(cfg_last) && (!cfg_diff || c % 2 == 0)) begin
          s.push_back(thr_up[c*12+4 +: 8]);
          s.push_back({thr_up[c*12 +: 4], thr_lo[c*12+8 +: 4]});
          s.push_back(thr_lo[c*12 +: 8]);
        end
      ws = 0;
    end else begin
      s.push_back(alarm_word[15:8]); s.push_back(alarm_word[7:0]);
      for (int i = 0; i < cnt; i++) begin
        s.push_back(fault_words[i*16+8 +: 8]); s.push_back(fault_words[i*16 +: 8]);
      end
      ws = s.size();
      for (int i = 0; i < cnt; i++) begin
        s.push_back(mcur[i][15:8]); s.push_back(mcur[i][7:0]);
      end
    end
    if (n < s.size()) return s[n];
    return s[ws + (n - ws) % (s.size() - ws)];
  endfunction

  task automatic rd(int n, int tag, bit gap);
    rd_on = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_req = 1; expq.push_back(exp_at(k)); tagq.push_back(tag); k++;
      if (gap) begin @(negedge clk); byte_req = 0; end
    end
    @(negedge clk); byte_req = 0;
    @(negedge clk);
  endtask

  task automatic fin();
    @(negedge clk); rd_end = 1;
    @(negedge clk); rd_end = 0;
    k = 0; rd_on = 0;
  endtask

  task automatic wr(logic [1:0] sl, logic [15:0] v);
    @(negedge clk); res_we = 1; res_slot = sl; res_data = v;
    if (!(rd_on && cfg_sel != 2'b11)) mcur[sl] = v;
    @(negedge clk); res_we = 0;
  endtask

  always @(negedge clk) if (rst_n && byte_vld) begin
    if (expq.size() == 0) chk(0, "R2 unexpected byte", {8'h0, byte_out}, 16'h0);
    else begin
      logic [7:0] e; int t;
      e = expq.pop_front(); t = tagq.pop_front();
      chk(byte_out == e, $sformatf("R%0d byte", t), {8'h0, byte_out}, {8'h0, e});
    end
  end

  initial begin
    #(PER*100000);
    chk(0, "watchdog", 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(byte_vld == 0 && byte_out == 0, "R1 reset outputs", {7'h0, byte_vld, byte_out}, 16'h0);
    rst_n = 1;
    // R1: results zero after reset; R3 order, R4 n=4, R5 wrap
    rd(22, 1, 1); fin();
    wr(0, 16'h1234); wr(1, 16'hBEEF); wr(2, 16'h0F0F); wr(3, 16'hC001);
    rd(22, 3, 0); fin();                           // R3 R5, back to back (R2)
    cfg_last = 2; rd(16, 4, 1); fin();             // R4 single-ended 3 slots
    cfg_diff = 1; cfg_last = 3; rd(12, 4, 0); fin(); // R4 differential 2 pairs
    cfg_last = 1; rd(8, 5, 0); fin();              // R4/R5 one pair
    cfg_diff = 0; cfg_last = 3;
    // R6: write during monitor read discarded
    rd(2, 6, 1); wr(0, 16'hDEAD); rd(18, 6, 1); fin();
    rd(12, 6, 0); fin();
    wr(0, 16'hD00D); rd(12, 6, 0); fin();
    // R7: end mid-read restarts; rd_end beats byte_req
    rd(3, 7, 1); fin(); rd(4, 7, 0);
    @(negedge clk); byte_req = 1; rd_end = 1;
    @(negedge clk); byte_req = 0; rd_end = 0; k = 0; rd_on = 0;
    chk(byte_vld == 0, "R7 end wins over request", {15'h0, byte_vld}, 16'h0);
    rd(2, 7, 0); fin();
    // R8/R9 readback
    cfg_sel = 2'b11; rd(15, 9, 1); fin();
    cfg_speed = 3'b010; cfg_irq_en = 0; rd(1, 8, 0); fin();
    cfg_diff = 1; rd(9, 9, 0); fin();
    cfg_diff = 0; cfg_last = 0; rd(5, 9, 0); fin();
    // R6: writes accepted during a readback read
    cfg_last = 3; rd(2, 9, 0); wr(2, 16'h5A5A); fin();
    cfg_sel = 2'b00; rd(22, 6, 0); fin();
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 missing bytes", 16'(expq.size()), 16'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule